// File: doc/BRIEF.md
# Quadrature and Timer Counter Channel

This block is one channel of a general-purpose counter/timer that sits on a 16-bit word register bus. It has a 24-bit counter. The counter can follow an A/B quadrature encoder at single, double or quadruple resolution. It can also step on an internal tick, with the direction chosen by software. Two preload words feed the counter. Software can apply them through a control-register command, or the block can apply them automatically: on a rising edge of the index input, or alternately at each terminal count. A capture flag, kept by a two-state machine, marks the terminal count. The flag can gate counting, and it drives the channel output through a polarity inversion. This gives a one-shot output and a pulse-train output with no extra hardware.

The capture machine has two states. CAP_CLEAR moves to CAP_SET on a terminal count. CAP_SET moves to CAP_CLEAR on a clear command. In alternating-reload mode, CAP_SET also moves to CAP_CLEAR on the next terminal count. A clear command wins over a terminal count that arrives in the same cycle. After reset the machine is in CAP_SET. Software reads the count as two words, and a latch keeps the two halves coherent.

Top module: `ctr_channel`

## Requirements
- R1: After reset the count is 0, the mode word reads 0, the control word reads 1 (capture flag set) and `ctr_out` is 1.
- R2: Bus word address 2 holds the mode word. It is readable and writable, and bit 15 always reads 0. The mode fields, from bit 14 down, are:
  - bit 14: preload select
  - bit 13: latch control
  - bit 12: software-direction enable
  - bit 11: down (1) / up (0)
  - bits 10:9: clock source (0 x1, 1 x2, 2 x4, 3 internal tick)
  - bits 8:7: enable control
  - bits 6:5: hardware enable source
  - bits 4:2: auto-load code
  - bit 1: output polarity
  - bit 0: output source

  Writes to address 0 (bits 15:0) and address 1 (bits 7:0) update preload 0 when bit 14 is 0, or preload 1 when bit 14 is 1.
- R3: Reading address 0 gives count bits 15:0. Reading address 1 gives latched count bits 23:16 in bits 7:0, with bits 15:8 reading zero.
- R4: With latch control 0, a read of address 0 captures the whole count, and a later read of address 1 returns the upper bits of that captured value. With latch control 1, the captured value is taken on each index rising edge, and address 0 returns the captured low word.
- R5: A write to address 3 acts on three bits:
  - bit 15 clears the count;
  - bit 14 loads preload 0, and wins over bit 15;
  - bit 3 clears the capture flag.

  Reading address 3 returns the flag in bit 0.
- R6: The quadrature phases pass through a synchronizer. A change in one phase counts up when the new A differs from the previous B, and down otherwise. Which changes count depends on the clock source:
  - x1 counts only A changes while B is 0;
  - x2 counts every A change;
  - x4 counts every single-phase change.
- R7: A sample in which both phases change does not move the count.
- R8: With clock source 3 the count steps once per cycle with `tick_en` high. The direction comes from bit 11. The count wraps modulo 2^24.
- R9: Enable control sets when the counter may count:
  - 0 stops counting;
  - 1 always counts;
  - 2 or 3 counts according to the hardware source: index high (0), index low (1), flag clear (2) or flag set (3).
- R10: A step that makes the count reach 0 while counting down, or all ones while counting up, sets the capture flag. With auto-load code 0 the count keeps that value.
- R11: With auto-load code 1, a terminal step reloads the count and toggles the flag. The count reloads preload 1 when the flag was clear and preload 0 when it was set. The output is then low for preload 0 ticks and high for preload 1 ticks.
- R12: With auto-load code 4, a synchronized index rising edge loads preload 0 once.
- R13: `ctr_out` equals the capture flag, or the inverse of the count enable when bit 0 is 1, inverted when bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe (drives the read latch) |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Index input (asynchronous) |
| tick_en | input | 1 | Internal clock tick, one step per high cycle |
| ctr_out | output | 1 | Channel output |

## Verification
The bench builds the channel with its default parameters: a 24-bit counter and a two-stage synchronizer. At this width a single down step from zero reaches all ones, and a single up step from one below all ones reaches the terminal count. Both the wrap and the upper-byte split of the readback can therefore be checked in a few cycles. The two-stage synchronizer fixes the input-to-count latency at three clock edges. The bench waits four cycles after each phase change, so it samples after that latency has settled.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int BUS_W = 16;

    localparam logic [1:0] A_PRE_LO = 2'd0;
    localparam logic [1:0] A_PRE_HI = 2'd1;
    localparam logic [1:0] A_MODE   = 2'd2;
    localparam logic [1:0] A_CTRL   = 2'd3;

    localparam int CTL_ZERO_BIT  = 15;
    localparam int CTL_LOAD_BIT  = 14;
    localparam int CTL_CLEAR_BIT = 3;

    localparam logic [1:0] SRC_X1   = 2'd0;
    localparam logic [1:0] SRC_X2   = 2'd1;
    localparam logic [1:0] SRC_X4   = 2'd2;
    localparam logic [1:0] SRC_TICK = 2'd3;

    localparam logic [1:0] HW_IDX_HIGH = 2'd0;
    localparam logic [1:0] HW_IDX_LOW  = 2'd1;
    localparam logic [1:0] HW_NOT_CAP  = 2'd2;
    localparam logic [1:0] HW_CAP      = 2'd3;

    localparam logic [2:0] AL_ALTERNATE = 3'd1;
    localparam logic [2:0] AL_INDEX     = 3'd4;

    typedef struct packed {
        logic       rsvd;
        logic       pre_sel;
        logic       latch_ctl;
        logic       sw_dir;
        logic       down;
        logic [1:0] clk_src;
        logic [1:0] en_ctl;
        logic [1:0] hw_src;
        logic [2:0] autold;
        logic       out_pol;
        logic       out_src;
    } mode_t;

    typedef enum logic {
        CAP_CLEAR = 1'b0,
        CAP_SET   = 1'b1
    } cap_state_e;

endpackage

// File: rtl/ctr_quad_decode.sv
module ctr_quad_decode
    import ctr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       enc_idx,
    input  logic [1:0] src,
    output logic       step,
    output logic       up,
    output logic       idx_rise,
    output logic       idx_lvl
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] cur;
    logic [NSIG-1:0] prev;

    assign raw = {enc_idx, enc_b, enc_a};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign cur[g] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    logic chg_a, chg_b;
    assign chg_a = cur[0] ^ prev[0];
    assign chg_b = cur[1] ^ prev[1];

    assign up       = cur[0] ^ prev[1];
    assign idx_rise = cur[2] & ~prev[2];
    assign idx_lvl  = cur[2];

    always_comb begin
        unique case (src)
            SRC_X1:  step = chg_a & ~chg_b & ~cur[1];
            SRC_X2:  step = chg_a & ~chg_b;
            SRC_X4:  step = chg_a ^ chg_b;
            default: step = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctr_capture_fsm.sv
module ctr_capture_fsm
    import ctr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_cmd,
    input  logic term,
    input  logic toggle,
    output logic flag
);
    cap_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_SET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_CLEAR: if (!clr_cmd && term) state_d = CAP_SET;
            CAP_SET:   if (clr_cmd || (term && toggle)) state_d = CAP_CLEAR;
            default:   state_d = CAP_SET;
        endcase
    end

    always_comb begin
        flag = (state_q == CAP_SET);
    end
endmodule

// File: rtl/ctr_count_engine.sv
module ctr_count_engine #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             up,
    input  logic             do_zero,
    input  logic             do_load,
    input  logic             idx_load,
    input  logic             alt_reload,
    input  logic             flag,
    input  logic [CNT_W-1:0] pre0,
    input  logic [CNT_W-1:0] pre1,
    output logic [CNT_W-1:0] count,
    output logic             term
);
    logic [CNT_W-1:0] nxt;
    logic             hit;

    always_comb begin
        nxt  = up ? count + 1'b1 : count - 1'b1;
        hit  = up ? (nxt == {CNT_W{1'b1}}) : (nxt == '0);
        term = step_en & hit & ~do_zero & ~do_load & ~idx_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               count <= '0;
        else if (do_load)         count <= pre0;
        else if (do_zero)         count <= '0;
        else if (idx_load)        count <= pre0;
        else if (step_en) begin
            if (hit && alt_reload) count <= flag ? pre0 : pre1;
            else                   count <= nxt;
        end
    end
endmodule

// File: rtl/ctr_channel.sv
module ctr_channel
    import ctr_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic             tick_en,
    output logic             ctr_out
);
    localparam int HI_W = CNT_W - BUS_W;

    mode_t                  mode_r;
    logic [1:0][CNT_W-1:0]  pre_q;
    logic [CNT_W-1:0]       count_q;
    logic [CNT_W-1:0]       lat_q;
    logic                   cap_flag;

    logic wr_lo, wr_hi, wr_mode, wr_ctl;
    assign wr_lo   = bus_wr && (bus_addr == A_PRE_LO);
    assign wr_hi   = bus_wr && (bus_addr == A_PRE_HI);
    assign wr_mode = bus_wr && (bus_addr == A_MODE);
    assign wr_ctl  = bus_wr && (bus_addr == A_CTRL);

    logic do_zero, do_load, clr_cmd;
    assign do_zero = wr_ctl & bus_wdata[CTL_ZERO_BIT];
    assign do_load = wr_ctl & bus_wdata[CTL_LOAD_BIT];
    assign clr_cmd = wr_ctl & bus_wdata[CTL_CLEAR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_r <= '0;
        else if (wr_mode) mode_r <= mode_t'({1'b0, bus_wdata[BUS_W-2:0]});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            for (int g = 0; g < 2; g++) begin
                if (mode_r.pre_sel == g[0]) begin
                    if (wr_lo) pre_q[g][BUS_W-1:0]     <= bus_wdata;
                    if (wr_hi) pre_q[g][CNT_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
                end
            end
        end
    end

    logic q_step, q_up, idx_rise, idx_lvl;

    ctr_quad_decode #(.SYNC_STAGES(SYNC_STAGES)) u_quad (
        .clk      (clk),
        .rst_n    (rst_n),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .enc_idx  (enc_idx),
        .src      (mode_r.clk_src),
        .step     (q_step),
        .up       (q_up),
        .idx_rise (idx_rise),
        .idx_lvl  (idx_lvl)
    );

    logic use_tick, dir_up, raw_step, hw_en, cnt_en, step_en;

    always_comb begin
        use_tick = (mode_r.clk_src == SRC_TICK);
        dir_up   = (mode_r.sw_dir || use_tick) ? ~mode_r.down : q_up;
        raw_step = use_tick ? tick_en : q_step;
        unique case (mode_r.hw_src)
            HW_IDX_HIGH: hw_en = idx_lvl;
            HW_IDX_LOW:  hw_en = ~idx_lvl;
            HW_NOT_CAP:  hw_en = ~cap_flag;
            default:     hw_en = cap_flag;
        endcase
        unique case (mode_r.en_ctl)
            2'd0:    cnt_en = 1'b0;
            2'd1:    cnt_en = 1'b1;
            default: cnt_en = hw_en;
        endcase
        step_en = raw_step & cnt_en;
    end

    logic term;

    ctr_count_engine #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .up         (dir_up),
        .do_zero    (do_zero),
        .do_load    (do_load),
        .idx_load   (idx_rise && (mode_r.autold == AL_INDEX)),
        .alt_reload (mode_r.autold == AL_ALTERNATE),
        .flag       (cap_flag),
        .pre0       (pre_q[0]),
        .pre1       (pre_q[1]),
        .count      (count_q),
        .term       (term)
    );

    ctr_capture_fsm u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_cmd (clr_cmd),
        .term    (term),
        .toggle  (mode_r.autold == AL_ALTERNATE),
        .flag    (cap_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_q <= '0;
        else if (!mode_r.latch_ctl && bus_rd && (bus_addr == A_PRE_LO))
            lat_q <= count_q;
        else if (mode_r.latch_ctl && idx_rise)
            lat_q <= count_q;
    end

    always_comb begin
        unique case (bus_addr)
            A_PRE_LO: bus_rdata = mode_r.latch_ctl ? lat_q[BUS_W-1:0] : count_q[BUS_W-1:0];
            A_PRE_HI: bus_rdata = {{(BUS_W-HI_W){1'b0}}, lat_q[CNT_W-1:BUS_W]};
            A_MODE:   bus_rdata = mode_r;
            default:  bus_rdata = {{(BUS_W-1){1'b0}}, cap_flag};
        endcase
    end

    assign ctr_out = (mode_r.out_src ? ~cnt_en : cap_flag) ^ mode_r.out_pol;
endmodule

// File: rtl/ctr_channel_chk.sv
module ctr_channel_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [15:0]      bus_wdata,
    input logic [15:0]      mode_w,
    input logic             cap_flag,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] pre0
);
    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == 2'd3);

    assert_zero_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[15] && !bus_wdata[14]) |=> (count == '0));

    assert_load_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[14]) |=> (count == $past(pre0)));

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[3]) |=> !cap_flag);

    assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w[8:7] == 2'd0 && mode_w[4:2] != 3'd4 && !ctl_wr) |=> $stable(count));

    assert_gate_on_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w[8] && mode_w[6:5] == 2'd2 && cap_flag && mode_w[4:2] != 3'd4 && !ctl_wr)
        |=> $stable(count));
endmodule

bind ctr_channel ctr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mode_w    (mode_r),
    .cap_flag  (cap_flag),
    .count     (count_q),
    .pre0      (pre_q[0])
);

// File: tb/tb_ctr_channel.sv
module tb_ctr_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, tick_en = 1'b0;
    logic        ctr_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] cur_ab = 2'b00;

    always #10 clk = ~clk;

    ctr_channel dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .tick_en(tick_en),
        .ctr_out(ctr_out)
    );

    // {clk_src[1:0], from {A,B}, to {A,B}, expected count from zero}
    localparam logic [29:0] QVEC [13] = '{
        {2'd2, 2'b00, 2'b10, 24'h000001},
        {2'd2, 2'b10, 2'b00, 24'hFFFFFF},
        {2'd2, 2'b11, 2'b01, 24'h000001},
        {2'd2, 2'b01, 2'b11, 24'hFFFFFF},
        {2'd2, 2'b00, 2'b11, 24'h000000},
        {2'd2, 2'b10, 2'b01, 24'h000000},
        {2'd0, 2'b00, 2'b10, 24'h000001},
        {2'd0, 2'b10, 2'b00, 24'hFFFFFF},
        {2'd0, 2'b10, 2'b11, 24'h000000},
        {2'd0, 2'b11, 2'b01, 24'h000000},
        {2'd1, 2'b11, 2'b01, 24'h000001},
        {2'd1, 2'b01, 2'b11, 24'hFFFFFF},
        {2'd1, 2'b00, 2'b01, 24'h000000}
    };

    function automatic logic [15:0] md(int src, int dirc, int down, int en, int hws,
                                       int al, int osrc, int pol, int prs, int lat);
        md = {1'b0, 1'(prs), 1'(lat), 1'(dirc), 1'(down), 2'(src), 2'(en),
              2'(hws), 3'(al), 1'(pol), 1'(osrc)};
    endfunction

    function automatic logic [1:0] fwd(logic [1:0] ab);
        case (ab)
            2'b00:   fwd = 2'b10;
            2'b10:   fwd = 2'b11;
            2'b11:   fwd = 2'b01;
            default: fwd = 2'b00;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_cnt(output logic [23:0] v);
        logic [15:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi[7:0], lo};
    endtask

    task automatic phase(logic [1:0] ab);
        @(negedge clk);
        enc_a = ab[1]; enc_b = ab[0]; cur_ab = ab;
        repeat (4) @(negedge clk);
    endtask

    task automatic idx_pulse();
        @(negedge clk); enc_idx = 1'b1;
        repeat (4) @(negedge clk); enc_idx = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [23:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 out", 32'(ctr_out), 32'd1);
        rd(2'd2, w); check("R1 mode", 32'(w), 32'h0);
        rd(2'd3, w); check("R1 flag", 32'(w), 32'h1);
        rd_cnt(c);   check("R1 count", 32'(c), 32'h0);

        // R2 mode readback, reserved bit reads zero
        wr(2'd2, 16'hDAA5);
        rd(2'd2, w); check("R2 mode", 32'(w), 32'h5AA5);
        wr(2'd2, 16'h0000);

        // R6 / R7 quadrature vector walk
        for (int i = 0; i < 13; i++) begin
            logic [1:0] src, fa, ta;
            src = QVEC[i][29:28]; fa = QVEC[i][27:26]; ta = QVEC[i][25:24];
            wr(2'd2, md(src, 0, 0, 1, 0, 0, 0, 0, 0, 0));
            phase(fa);
            wr(2'd3, 16'h8000);
            phase(ta);
            rd_cnt(c);
            check(((fa ^ ta) == 2'b11) ? "R7 invalid" : "R6 decode", 32'(c), 32'(QVEC[i][23:0]));
        end

        // R8 internal tick up
        wr(2'd2, md(3, 1, 0, 1, 0, 0, 0, 0, 0, 0));
        wr(2'd3, 16'h8000);
        @(negedge clk); tick_en = 1'b1;
        repeat (5) @(negedge clk); tick_en = 1'b0;
        rd_cnt(c); check("R8 tick up", 32'(c), 32'h5);

        // R8 wrap down from zero, R3 high word upper byte zero
        wr(2'd2, md(3, 1, 1, 1, 0, 0, 0, 0, 0, 0));
        wr(2'd3, 16'h8000);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        rd(2'd0, w); check("R3 low word", 32'(w), 32'hFFFF);
        rd(2'd1, w); check("R3 high word", 32'(w), 32'h00FF);

        // R5 clear flag; R10 terminal count down
        wr(2'd3, 16'h0008);
        rd(2'd3, w); check("R5 flag clear", 32'(w), 32'h0);
        wr(2'd0, 16'h0002); wr(2'd1, 16'h0000); wr(2'd3, 16'h4000);
        @(negedge clk); tick_en = 1'b1;
        repeat (2) @(negedge clk); tick_en = 1'b0;
        rd(2'd3, w); check("R10 flag down", 32'(w), 32'h1);
        rd_cnt(c);   check("R10 count held", 32'(c), 32'h0);

        // R10 terminal count up
        wr(2'd2, md(3, 1, 0, 1, 0, 0, 0, 0, 0, 0));
        wr(2'd0, 16'hFFFE); wr(2'd1, 16'h00FF); wr(2'd3, 16'h4008);
        rd(2'd3, w); check("R10 flag cleared", 32'(w), 32'h0);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        rd(2'd3, w); check("R10 flag up", 32'(w), 32'h1);

        // R5 load wins over zero
        wr(2'd2, md(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(2'd0, 16'hBCDE); wr(2'd1, 16'h000A);
        wr(2'd3, 16'hC000);
        rd_cnt(c); check("R5 load priority", 32'(c), 32'h0ABCDE);
        wr(2'd3, 16'h8000);
        rd_cnt(c); check("R5 zero", 32'(c), 32'h0);

        // R2 preload select: writes with select 1 leave preload 0 intact
        wr(2'd2, md(0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        wr(2'd0, 16'h1111); wr(2'd1, 16'h0022);
        wr(2'd2, md(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(2'd3, 16'h4000);
        rd_cnt(c); check("R2 preload select", 32'(c), 32'h0ABCDE);

        // R9 / R13 / R10 one-shot gated by the flag
        wr(2'd0, 16'h0004); wr(2'd1, 16'h0000);
        wr(2'd2, md(3, 1, 1, 2, 2, 0, 0, 1, 0, 0));
        @(negedge clk); tick_en = 1'b1;
        wr(2'd3, 16'h4000);
        repeat (3) @(negedge clk);
        rd_cnt(c); check("R9 gated by flag", 32'(c), 32'h4);
        check("R13 polarity", 32'(ctr_out), 32'd0);
        wr(2'd3, 16'h0008);
        for (int k = 0; k < 8; k++) begin
            check("R10 one-shot out", 32'(ctr_out), (k < 4) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        rd_cnt(c); check("R9 stopped", 32'(c), 32'h0);
        tick_en = 1'b0;

        // R13 output from enable
        wr(2'd2, md(0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
        check("R13 not enable off", 32'(ctr_out), 32'd1);
        wr(2'd2, md(0, 0, 0, 1, 0, 0, 1, 0, 0, 0));
        check("R13 not enable on", 32'(ctr_out), 32'd0);
        wr(2'd2, md(0, 0, 0, 1, 0, 0, 1, 1, 0, 0));
        check("R13 inverted", 32'(ctr_out), 32'd1);

        // R11 pulse train: preload 0 = 3 (low), preload 1 = 2 (high)
        wr(2'd2, md(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(2'd0, 16'h0003); wr(2'd1, 16'h0000);
        wr(2'd2, md(0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        wr(2'd0, 16'h0002); wr(2'd1, 16'h0000);
        wr(2'd2, md(3, 1, 1, 1, 0, 1, 0, 0, 1, 0));
        @(negedge clk); tick_en = 1'b1;
        wr(2'd3, 16'h4008);
        for (int k = 0; k < 10; k++) begin
            check("R11 pulse train", 32'(ctr_out), ((k % 5) >= 3) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        tick_en = 1'b0;

        // R12 index auto-load
        wr(2'd2, md(2, 0, 0, 1, 0, 0, 0, 0, 0, 0));
        wr(2'd0, 16'h3456); wr(2'd1, 16'h0012);
        wr(2'd2, md(2, 0, 0, 1, 0, 4, 0, 0, 0, 0));
        wr(2'd3, 16'h8000);
        idx_pulse();
        rd_cnt(c); check("R12 index load", 32'(c), 32'h123456);
        phase(fwd(cur_ab));
        rd_cnt(c); check("R12 single load", 32'(c), 32'h123457);

        // R4 latch on read
        wr(2'd2, md(2, 0, 0, 1, 0, 0, 0, 0, 0, 0));
        wr(2'd0, 16'hFFFF); wr(2'd1, 16'h0000); wr(2'd3, 16'h4000);
        rd(2'd0, w); check("R4 low read", 32'(w), 32'hFFFF);
        phase(fwd(cur_ab));
        rd(2'd1, w); check("R4 high coherent", 32'(w), 32'h0000);
        rd(2'd0, w); check("R4 low after step", 32'(w), 32'h0000);
        rd(2'd1, w); check("R4 high after step", 32'(w), 32'h0001);

        // R4 latch on index
        wr(2'd2, md(2, 0, 0, 1, 0, 0, 0, 0, 0, 1));
        wr(2'd0, 16'h0010); wr(2'd1, 16'h0000); wr(2'd3, 16'h4000);
        idx_pulse();
        phase(fwd(cur_ab));
        rd(2'd0, w); check("R4 index latch", 32'(w), 32'h0010);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule